// File: doc/BRIEF.md
# Multi-Mode Synthesizer Programming Interface

This block is the control front end of an integer-N frequency synthesizer. It receives the divider settings in one of three ways: a serial shift bus, an 8-bit parallel bus with three section strobes, or static pins that are wired directly to the counter inputs. Its outputs are the selected main-counter value M (9 bits), the swallow-counter value A (4 bits), the reference-counter value R (6 bits), the prescaler-enable bit, and five decoded enhancement control bits.

Two 20-bit registers hold the settings. The primary register is written by either bus. The secondary (hop) register takes a copy of the primary register on a copy strobe. A frequency-select input chooses which of the two drives the counters. This lets the next setting be loaded while the current one is in use, and then switched in on a single strobe. A separate 8-bit enhancement register has its own shift stage and holding buffer. In serial mode it commits on the falling edge of its strobe.

The serial clock and all strobes are asynchronous to the system clock. They pass through two-flop synchronizers, and every load fires on an edge detected in the system clock domain. The bus data passes through synchronizers of the same depth, so that it stays aligned with its strobes. The system clock must run at least four times as fast as the serial clock. Each level of the serial clock and of every strobe must last at least two system clocks, and bus data must stay stable while its strobe edge passes through the synchronizers. The mode, frequency-select and enhancement-enable inputs are treated as static configuration and are not synchronized.

Top module: `synth_prog_if`

## Requirements
- R1: With `bus_direct`=1 the outputs come straight from the pins: `m_val`={2'b00,`dir_m`}, `r_val`={2'b00,`dir_r`}, `a_val`=`dir_a`, `pre_en`=`dir_pre_en`. The enhancement outputs are all 0 in this mode.
- R2: Serial mode (`bus_direct`=0, `ser_sel`=1). While `ser_wr` and `enh_wr` are both low, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the primary word, and the existing bits move toward bit 19. After 20 edges, the first bit taken is word bit 19.
- R3: Serial mode. While `enh_wr` is high and `ser_wr` is low, each `ser_clk` rise shifts into an 8-bit enhancement stage instead, and the first bit taken ends in bit 7. The primary word does not change. The stage is copied into the enhancement buffer only on the falling edge of `enh_wr`, so the outputs do not change before that edge.
- R4: The secondary word takes the primary word on a rising edge of `hop_wr` in serial or parallel mode. In serial mode a rising edge of `ser_wr` also does this. At no other time does the secondary word change.
- R5: Parallel mode (`bus_direct`=0, `ser_sel`=0). On the rising edge of `wr_hi`, `pdata[3:0]` goes to word bits 19:16. On the rising edge of `wr_mid`, `pdata` goes to bits 15:8. On the rising edge of `wr_lo`, `pdata` goes to bits 7:0.
- R6: Parallel mode. On a rising edge of `enh_wr`, `pdata` is written directly into the enhancement buffer, with `pdata[k]` going to bit k.
- R7: Outside direct mode, `freq_sel`=1 selects the primary word as the counter source, and `freq_sel`=0 selects the secondary word.
- R8: Word layout (bit 19 down to 0): R5, R4, M8, M7, prescaler enable, M6..M0, R3..R0, A3..A0. Enhancement outputs are active only while `enh_n`=0, and are 0 otherwise. The bit mapping is: bit 3 to `pwr_down`, bit 4 to `cnt_load`, bit 5 to `dout_msel`, bit 6 to `dout_prescale`, bit 7 to `mon_off`. Bits 2:0 are reserved and reach no output.
- R9: In direct mode, strobes, serial clock and bus activity leave the primary, secondary and enhancement registers unchanged.
- R10: After reset the primary, secondary and enhancement registers are all zero. Each load is visible at the outputs within four system clocks after its input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_direct | input | 1 | 1 selects direct pin mode |
| ser_sel | input | 1 | When not direct: 1 selects serial mode, 0 selects parallel mode |
| freq_sel | input | 1 | 1 selects the primary word, 0 selects the secondary word |
| enh_n | input | 1 | Active-low enable for the enhancement outputs |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, first bit most significant |
| ser_wr | input | 1 | Serial write strobe; its rising edge copies primary to secondary |
| enh_wr | input | 1 | Enhancement strobe |
| hop_wr | input | 1 | Hop strobe; its rising edge copies primary to secondary |
| wr_hi | input | 1 | Parallel strobe for word bits 19:16 |
| wr_mid | input | 1 | Parallel strobe for word bits 15:8 |
| wr_lo | input | 1 | Parallel strobe for word bits 7:0 |
| pdata | input | 8 | Parallel data bus |
| dir_m | input | 7 | Direct-mode M bits 6:0 |
| dir_a | input | 4 | Direct-mode A value |
| dir_r | input | 4 | Direct-mode R bits 3:0 |
| dir_pre_en | input | 1 | Direct-mode prescaler enable |
| m_val | output | 9 | Selected M value |
| a_val | output | 4 | Selected A value |
| r_val | output | 6 | Selected R value |
| pre_en | output | 1 | Selected prescaler enable |
| pwr_down | output | 1 | Power-down control |
| cnt_load | output | 1 | Continuous counter-load control |
| dout_msel | output | 1 | Route modulus select to data-out |
| dout_prescale | output | 1 | Route raw prescaler output to data-out |
| mon_off | output | 1 | Disable divider monitor outputs |

## Verification
A wrong bit in the primary word appears on the M, A, R or prescaler outputs as soon as `freq_sel` is high. A wrong secondary word is hidden until `freq_sel` goes low. For that reason the bench reads each word through the selector both before and after every copy strobe. An error in the serial enhancement stage is invisible until the `enh_wr` falling edge, so the bench checks the outputs just before that edge, where they must still hold the old value, and again about four clocks after it. Direct-mode writes that leak into the registers show up only after the bench returns to parallel mode and reads back both words and the enhancement buffer.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
    localparam int PRIM_W = 20;
    localparam int ENH_W  = 8;
    localparam int PBUS_W = 8;
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int R_W    = 6;
    localparam int DM_W   = 7;
    localparam int DR_W   = 4;

    // strobe vector positions
    localparam int ST_SCLK = 0;
    localparam int ST_SWR  = 1;
    localparam int ST_EWR  = 2;
    localparam int ST_HOP  = 3;
    localparam int ST_WHI  = 4;
    localparam int ST_WMID = 5;
    localparam int ST_WLO  = 6;
    localparam int NUM_ST  = 7;

    // enhancement bit positions
    localparam int EB_PWR  = 3;
    localparam int EB_LOAD = 4;
    localparam int EB_MSEL = 5;
    localparam int EB_PRE  = 6;
    localparam int EB_MON  = 7;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } mode_e;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic           pre;
    } div_cfg_t;

    typedef struct packed {
        logic [PRIM_W-1:0] prim;
        logic [PRIM_W-1:0] sec;
        logic [ENH_W-1:0]  eshift;
        logic [ENH_W-1:0]  ehold;
        logic [NUM_ST-1:0] st_prev;
    } reg_state_t;

    // word layout: [19:18]=R5:R4 [17:16]=M8:M7 [15]=pre [14:8]=M6:M0 [7:4]=R3:R0 [3:0]=A
    function automatic div_cfg_t unpack_word(input logic [PRIM_W-1:0] w);
        div_cfg_t c;
        c.r   = {w[19:18], w[7:4]};
        c.m   = {w[17:16], w[14:8]};
        c.a   = w[3:0];
        c.pre = w[15];
        return c;
    endfunction
endpackage

// File: rtl/synprog_sync.sv
module synprog_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/synprog_regs.sv
module synprog_regs
    import synprog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  mode_e                mode,
    input  logic [NUM_ST-1:0]    st_lvl,
    input  logic                 sdata,
    input  logic [PBUS_W-1:0]    pdata,
    output logic [PRIM_W-1:0]    prim_word,
    output logic [PRIM_W-1:0]    sec_word,
    output logic [ENH_W-1:0]     enh_word
);
    reg_state_t        st_d, st_q;
    logic [NUM_ST-1:0] rise, fall;

    always_comb begin
        rise       = st_lvl & ~st_q.st_prev;
        fall       = ~st_lvl & st_q.st_prev;
        st_d       = st_q;
        st_d.st_prev = st_lvl;
        case (mode)
            MODE_SER: begin
                if (rise[ST_SCLK] && !st_lvl[ST_SWR]) begin
                    if (!st_lvl[ST_EWR]) st_d.prim   = {st_q.prim[PRIM_W-2:0], sdata};
                    else                 st_d.eshift = {st_q.eshift[ENH_W-2:0], sdata};
                end
                if (rise[ST_SWR] || rise[ST_HOP]) st_d.sec   = st_q.prim;
                if (fall[ST_EWR])                 st_d.ehold = st_q.eshift;
            end
            MODE_PAR: begin
                if (rise[ST_WHI])  st_d.prim[19:16] = pdata[3:0];
                if (rise[ST_WMID]) st_d.prim[15:8]  = pdata;
                if (rise[ST_WLO])  st_d.prim[7:0]   = pdata;
                if (rise[ST_HOP])  st_d.sec         = st_q.prim;
                if (rise[ST_EWR])  st_d.ehold       = pdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prim_word = st_q.prim;
    assign sec_word  = st_q.sec;
    assign enh_word  = st_q.ehold;

    // R4: the secondary word only moves on a copy edge
    p_sec_only_on_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise[ST_HOP] || (mode == MODE_SER && rise[ST_SWR])) |=> $stable(st_q.sec));

    // R4: a hop edge copies the word held at that edge
    p_hop_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_DIR && rise[ST_HOP]) |=> (st_q.sec == $past(st_q.prim)));

    // R9: direct mode freezes every programmable register
    p_direct_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIR) |=> ($stable(st_q.prim) && $stable(st_q.sec) && $stable(st_q.ehold)));

    // R3: serial enhancement buffer changes only on the strobe falling edge
    p_enh_commit_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SER && !fall[ST_EWR]) |=> $stable(st_q.ehold));

    // R3: shifting into the enhancement stage leaves the primary word alone
    p_enh_shift_keeps_prim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SER && st_lvl[ST_EWR]) |=> $stable(st_q.prim));
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import synprog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_direct,
    input  logic              ser_sel,
    input  logic              freq_sel,
    input  logic              enh_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_wr,
    input  logic              enh_wr,
    input  logic              hop_wr,
    input  logic              wr_hi,
    input  logic              wr_mid,
    input  logic              wr_lo,
    input  logic [7:0]        pdata,
    input  logic [6:0]        dir_m,
    input  logic [3:0]        dir_a,
    input  logic [3:0]        dir_r,
    input  logic              dir_pre_en,
    output logic [8:0]        m_val,
    output logic [3:0]        a_val,
    output logic [5:0]        r_val,
    output logic              pre_en,
    output logic              pwr_down,
    output logic              cnt_load,
    output logic              dout_msel,
    output logic              dout_prescale,
    output logic              mon_off
);
    localparam int DATA_W = PBUS_W + 1;

    mode_e             mode;
    logic [NUM_ST-1:0] st_raw, st_lvl;
    logic [DATA_W-1:0] dat_lvl;
    logic [PRIM_W-1:0] prim_word, sec_word;
    logic [ENH_W-1:0]  enh_word, enh_act;
    div_cfg_t          cfg;

    assign mode = bus_direct ? MODE_DIR : (ser_sel ? MODE_SER : MODE_PAR);

    always_comb begin
        st_raw          = '0;
        st_raw[ST_SCLK] = ser_clk;
        st_raw[ST_SWR]  = ser_wr;
        st_raw[ST_EWR]  = enh_wr;
        st_raw[ST_HOP]  = hop_wr;
        st_raw[ST_WHI]  = wr_hi;
        st_raw[ST_WMID] = wr_mid;
        st_raw[ST_WLO]  = wr_lo;
    end

    synprog_sync #(.W(NUM_ST), .STAGES(SYNC_STAGES)) i_strobe_sync (
        .clk(clk), .rst_n(rst_n), .d(st_raw), .q(st_lvl));

    synprog_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_data_sync (
        .clk(clk), .rst_n(rst_n), .d({ser_data, pdata}), .q(dat_lvl));

    synprog_regs i_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode), .st_lvl(st_lvl),
        .sdata(dat_lvl[PBUS_W]), .pdata(dat_lvl[PBUS_W-1:0]),
        .prim_word(prim_word), .sec_word(sec_word), .enh_word(enh_word));

    always_comb begin
        if (mode == MODE_DIR) begin
            cfg.r   = {{(R_W-DR_W){1'b0}}, dir_r};
            cfg.m   = {{(M_W-DM_W){1'b0}}, dir_m};
            cfg.a   = dir_a;
            cfg.pre = dir_pre_en;
            enh_act = '0;
        end else begin
            cfg     = unpack_word(freq_sel ? prim_word : sec_word);
            enh_act = enh_n ? '0 : enh_word;
        end
    end

    assign m_val         = cfg.m;
    assign a_val         = cfg.a;
    assign r_val         = cfg.r;
    assign pre_en        = cfg.pre;
    assign pwr_down      = enh_act[EB_PWR];
    assign cnt_load      = enh_act[EB_LOAD];
    assign dout_msel     = enh_act[EB_MSEL];
    assign dout_prescale = enh_act[EB_PRE];
    assign mon_off       = enh_act[EB_MON];

    // R8: no enhancement control leaks while the enable is high
    p_enh_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n |-> !(pwr_down || cnt_load || dout_msel || dout_prescale || mon_off));

    // R1: direct mode never shows the extended counter bits
    p_direct_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_direct |-> (m_val[8:7] == 2'b00 && r_val[5:4] == 2'b00));
endmodule

// File: tb/test_synth_prog_if.sv
module test_synth_prog_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_direct = 0, ser_sel = 0, freq_sel = 1, enh_n = 1;
    logic ser_clk = 0, ser_data = 0, ser_wr = 0, enh_wr = 0, hop_wr = 0;
    logic wr_hi = 0, wr_mid = 0, wr_lo = 0;
    logic [7:0] pdata = '0;
    logic [6:0] dir_m = '0;
    logic [3:0] dir_a = '0, dir_r = '0;
    logic dir_pre_en = 0;
    logic [8:0] m_val; logic [3:0] a_val; logic [5:0] r_val;
    logic pre_en, pwr_down, cnt_load, dout_msel, dout_prescale, mon_off;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [19:0] exp_prim = '0, exp_sec = '0;
    logic [7:0]  exp_enh = '0;

    always #2.5 clk = ~clk;

    synth_prog_if i_synth_prog_if (.*);

    function automatic logic [19:0] cfg_of(input logic [19:0] w);
        return {w[19:18], w[7:4], w[17:16], w[14:8], w[3:0], w[15]};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_words(input string tag);
        freq_sel = 1; tick(1);
        check({tag, " primary"}, 32'({r_val, m_val, a_val, pre_en}), 32'(cfg_of(exp_prim)));
        freq_sel = 0; tick(1);
        check({tag, " secondary"}, 32'({r_val, m_val, a_val, pre_en}), 32'(cfg_of(exp_sec)));
    endtask

    task automatic check_enh(input string tag);
        enh_n = 0; tick(1);
        check({tag, " enh on"}, 32'({mon_off, dout_prescale, dout_msel, cnt_load, pwr_down}),
              32'(exp_enh[7:3]));
        enh_n = 1; tick(1);
        check({tag, " enh off R8"}, 32'({mon_off, dout_prescale, dout_msel, cnt_load, pwr_down}), 0);
    endtask

    task automatic ser_bit(input logic b);
        ser_data = b; tick(4);
        ser_clk = 1; tick(4);
        ser_clk = 0;
    endtask

    task automatic pulse(ref logic s);
        s = 1; tick(4);
        s = 0; tick(4);
    endtask

    task automatic par_write(input logic [19:0] w);
        pdata = {4'h0, w[19:16]}; tick(2); pulse(wr_hi);
        pdata = w[15:8];          tick(2); pulse(wr_mid);
        pdata = w[7:0];           tick(2); pulse(wr_lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        tick(3); rst_n = 1; tick(2);
        // R10: reset state
        check_words("R10 reset");
        check_enh("R10 reset");

        // Parallel mode: R5 R7 R4 R6 R8
        for (int it = 0; it < 10; it++) begin
            logic [19:0] w;
            logic [7:0] e;
            w = (it == 0) ? 20'hFFFFF : 20'($urandom);
            par_write(w);
            exp_prim = w;
            check_words("R5 R7 par before hop");
            pulse(hop_wr); exp_sec = exp_prim;
            check_words("R4 par hop");
            e = (it == 1) ? 8'h07 : 8'($urandom);
            pdata = e; tick(2); pulse(enh_wr); exp_enh = e;
            check_enh("R6 par enh");
        end

        // Serial mode: R2 R4 R3
        ser_sel = 1; tick(4);
        for (int it = 0; it < 10; it++) begin
            logic [19:0] w;
            logic [7:0] e;
            w = (it == 0) ? 20'h80001 : 20'($urandom);
            for (int i = 19; i >= 0; i--) ser_bit(w[i]);
            tick(4); exp_prim = w;
            check_words("R2 R7 ser shift");
            if (it % 2 == 0) pulse(ser_wr); else pulse(hop_wr);
            exp_sec = exp_prim;
            check_words("R4 ser copy");
            e = 8'($urandom);
            enh_wr = 1; tick(4);
            for (int i = 7; i >= 0; i--) ser_bit(e[i]);
            tick(4);
            check_enh("R3 before fall");
            check_words("R3 prim untouched");
            enh_wr = 0; tick(4); exp_enh = e;
            check_enh("R3 after fall");
        end

        // Direct mode: R1 R9
        bus_direct = 1; tick(2);
        for (int it = 0; it < 8; it++) begin
            dir_m = (it == 0) ? 7'h7F : 7'($urandom);
            dir_a = 4'($urandom); dir_r = (it == 0) ? 4'hF : 4'($urandom);
            dir_pre_en = 1'($urandom);
            enh_n = 0;
            freq_sel = 1'($urandom); tick(1);
            check("R1 direct cfg", 32'({r_val, m_val, a_val, pre_en}),
                  32'({2'b00, dir_r, 2'b00, dir_m, dir_a, dir_pre_en}));
            check("R1 direct enh off", 32'({mon_off, dout_prescale, dout_msel, cnt_load, pwr_down}), 0);
            enh_n = 1;
            pdata = 8'($urandom); ser_sel = 1'($urandom); tick(2);
            pulse(wr_hi); pulse(wr_mid); pulse(wr_lo); pulse(hop_wr);
            ser_bit(1'b1); pulse(ser_wr);
            pulse(enh_wr);
        end
        ser_sel = 0; bus_direct = 0; tick(4);
        check_words("R9 after direct");
        check_enh("R9 after direct");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule